// File: doc/BRIEF.md
# Global-History Hashed Branch Direction Predictor

This block predicts whether one conditional branch per cycle will be taken. It keeps a register of the outcomes of the most recent resolved branches, whichever branch they came from. It forms a table index by XORing that history with the word-address bits of the branch PC. The index selects a 2-bit saturating counter, and the upper bit of that counter is the prediction. Because the history is part of the index, one static branch can train a different counter for each recent outcome pattern.

The front end presents a PC on the lookup side and receives the prediction together with the index it used. It should keep that index with the branch. When the branch resolves, the back end returns the index and the real outcome on the update side. The counter at that index is trained, and the outcome is shifted into the history. A restore input overwrites the history with a value supplied by the pipeline, for recovery after a flush.

Top module: `ghist_xor_pred`

## Requirements
- R1: While reset is held low and after it is released, every counter holds 1 (weakly not taken), so every lookup predicts not taken, and the history reads 0.
- R2: The lookup index is PC bits [11:2] XOR the current 10-bit history, and it appears on `pred_idx` in the same cycle as the PC.
- R3: `pred_taken` is 1 exactly when the counter at the lookup index holds 2 or 3.
- R4: An update with outcome taken (1) raises the addressed counter by one, and a counter at 3 stays at 3.
- R5: An update with outcome not taken (0) lowers the addressed counter by one, and a counter at 0 stays at 0.
- R6: Each update without restore shifts the history left by one place, with the new outcome entering at bit 0 (1 = taken).
- R7: Training uses the index given on `upd_idx`, even when the current history would hash the same PC to a different index.
- R8: A lookup and an update in the same cycle are both served, and the lookup returns the counter value from before the update.
- R9: A restore loads `rest_hist` into the history on the next edge and wins over the shift of a simultaneous update, while that update still trains its counter.
- R10: PC bits [1:0] and all PC bits above bit 11 have no effect on the index or the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | PC of the branch being looked up |
| pred_idx | output | 10 | Table index used for this lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_en | input | 1 | A resolved branch is presented for training |
| upd_idx | input | 10 | Index recorded at prediction time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| rest_en | input | 1 | Overwrite the history |
| rest_hist | input | 10 | History value to load |
| ghist | output | 10 | Current global history |

## Verification
The same counter is driven taken several times past saturation and then not taken several times past zero. Predictions are read back between steps, which separates correct saturation from wraparound and shows whether the threshold sits at 2. Further runs let the history shift freely so that the hash changes while `upd_idx` stays fixed. This shows whether training follows the supplied index or the current hash. Restores are applied alone and together with updates to show which one wins. The same counter index is reached through PCs with different low offset bits and different high bits, to show that those bits are ignored. Updates that target the index being looked up in the same cycle show whether the read happens before or after the write.

// File: rtl/ghist_xor_pred.sv
module ghist_xor_pred #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pred_pc,
  output logic [IDX_W-1:0] pred_idx,
  output logic             pred_taken,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  input  logic             rest_en,
  input  logic [IDX_W-1:0] rest_hist,
  output logic [IDX_W-1:0] ghist
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] tbl [ENTRIES];
  logic [1:0] upd_ctr;
  logic       unused_pc_bits;

  assign unused_pc_bits = ^{pred_pc[PC_W-1:OFS+IDX_W], pred_pc[OFS-1:0]};
  assign pred_idx   = pred_pc[OFS +: IDX_W] ^ ghist;
  assign pred_taken = tbl[pred_idx][1];
  assign upd_ctr    = tbl[upd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= 2'd1;
    end else if (upd_en) begin
      if (upd_taken && upd_ctr != 2'd3)
        tbl[upd_idx] <= upd_ctr + 2'd1;
      else if (!upd_taken && upd_ctr != 2'd0)
        tbl[upd_idx] <= upd_ctr - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ghist <= '0;
    else if (rest_en) ghist <= rest_hist;
    else if (upd_en)  ghist <= {ghist[IDX_W-2:0], upd_taken};
  end

  // R4
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && upd_ctr == 2'd3) |=> tbl[$past(upd_idx)] == 2'd3);

  // R5
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && upd_ctr == 2'd0) |=> tbl[$past(upd_idx)] == 2'd0);

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !rest_en) |=> ghist[0] == $past(upd_taken));

  // R9
  hist_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rest_en |=> ghist == $past(rest_hist));

  // R1
  reset_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (ghist == '0 && !pred_taken));
endmodule

// File: tb/ghist_xor_pred_tb_top.sv
`timescale 1ns/1ps
module ghist_xor_pred_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic [9:0]  pred_idx;
  logic        pred_taken;
  logic        upd_en = 1'b0;
  logic [9:0]  upd_idx = '0;
  logic        upd_taken = 1'b0;
  logic        rest_en = 1'b0;
  logic [9:0]  rest_hist = '0;
  logic [9:0]  ghist;

  int checks = 0;
  int errors = 0;
  logic [1:0] ref_tbl [1024];
  logic [9:0] ref_hist;

  always #10 clk = ~clk;

  ghist_xor_pred dut_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_idx(pred_idx),
    .pred_taken(pred_taken), .upd_en(upd_en), .upd_idx(upd_idx),
    .upd_taken(upd_taken), .rest_en(rest_en), .rest_hist(rest_hist),
    .ghist(ghist));

  // pc[54:23] upd_en[22] upd_idx[21:12] upd_taken[11] rest_en[10] rest_hist[9:0]
  localparam int NV = 16;
  localparam logic [54:0] VEC [NV] = '{
    {32'h0000_0010, 1'b1, 10'h004, 1'b1, 1'b1, 10'h000},
    {32'h0000_0010, 1'b1, 10'h004, 1'b1, 1'b1, 10'h000},
    {32'h0000_0010, 1'b1, 10'h004, 1'b1, 1'b1, 10'h000},
    {32'h0000_0013, 1'b1, 10'h004, 1'b0, 1'b1, 10'h000},
    {32'h0000_0011, 1'b1, 10'h004, 1'b0, 1'b1, 10'h000},
    {32'h0000_0010, 1'b1, 10'h004, 1'b0, 1'b1, 10'h000},
    {32'hFFFF_F010, 1'b1, 10'h004, 1'b0, 1'b1, 10'h000},
    {32'h0000_0010, 1'b1, 10'h004, 1'b1, 1'b0, 10'h000},
    {32'h0000_0010, 1'b1, 10'h3FF, 1'b1, 1'b0, 10'h000},
    {32'h0000_02A0, 1'b1, 10'h0AB, 1'b1, 1'b0, 10'h000},
    {32'h0000_02A0, 1'b1, 10'h0AB, 1'b1, 1'b0, 10'h000},
    {32'h0000_02A0, 1'b1, 10'h0AB, 1'b0, 1'b0, 10'h000},
    {32'h0000_0000, 1'b0, 10'h000, 1'b0, 1'b1, 10'h155},
    {32'h8000_0554, 1'b1, 10'h001, 1'b1, 1'b0, 10'h000},
    {32'h0000_0554, 1'b0, 10'h000, 1'b1, 1'b0, 10'h000},
    {32'h0000_0FFC, 1'b1, 10'h3FE, 1'b0, 1'b0, 10'h000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_reset();
    for (int i = 0; i < 1024; i++) ref_tbl[i] = 2'd1;
    ref_hist = '0;
  endtask

  task automatic step(input logic [31:0] pc, input bit ue, input logic [9:0] ui,
                      input bit ut, input bit re, input logic [9:0] rh);
    logic [9:0] eidx;
    @(negedge clk);
    pred_pc = pc; upd_en = ue; upd_idx = ui; upd_taken = ut;
    rest_en = re; rest_hist = rh;
    #1;
    eidx = pc[11:2] ^ ref_hist;
    check(pred_idx == eidx, "R2/R10 index", 32'(pred_idx), 32'(eidx));
    check(pred_taken == (ref_tbl[eidx] >= 2'd2), "R3/R8 prediction",
          32'(pred_taken), 32'(ref_tbl[eidx] >= 2'd2));
    @(posedge clk);
    if (ue) begin
      if (ut && ref_tbl[ui] != 2'd3) ref_tbl[ui] = ref_tbl[ui] + 2'd1;
      else if (!ut && ref_tbl[ui] != 2'd0) ref_tbl[ui] = ref_tbl[ui] - 2'd1;
    end
    if (re) ref_hist = rh;
    else if (ue) ref_hist = {ref_hist[8:0], ut};
    #1;
    check(ghist == ref_hist, "R6/R9 history", 32'(ghist), 32'(ref_hist));
    upd_en = 1'b0; rest_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ref_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(ghist == 10'h0, "R1 history during reset", 32'(ghist), 0);
    check(pred_taken == 1'b0, "R1 no taken during reset", 32'(pred_taken), 0);
    rst_n = 1'b1;
    // R1: reset leaves weakly-not-taken everywhere
    foreach (VEC[k]) begin
      pred_pc = VEC[k][54:23];
      #1;
      check(pred_taken == 1'b0, "R1 counters after reset", 32'(pred_taken), 0);
    end

    foreach (VEC[k])
      step(VEC[k][54:23], VEC[k][22], VEC[k][21:12], VEC[k][11], VEC[k][10], VEC[k][9:0]);

    // R7: train by supplied index while history points elsewhere
    step(32'h0, 1'b0, 10'h0, 1'b0, 1'b1, 10'h0F0);
    step(32'h0000_0040, 1'b1, 10'h010, 1'b1, 1'b0, 10'h0);
    step(32'h0000_0040, 1'b1, 10'h010, 1'b1, 1'b1, 10'h000);
    @(negedge clk);
    pred_pc = 32'h0000_0040;
    #1;
    check(pred_idx == 10'h010, "R7 index with cleared history", 32'(pred_idx), 32'h10);
    check(pred_taken == 1'b1, "R7 trained counter by supplied index", 32'(pred_taken), 1);

    // R8: same-cycle update of the looked-up entry reads old value
    step(32'h0000_0040, 1'b1, 10'h010, 1'b0, 1'b1, 10'h000);
    step(32'h0000_0040, 1'b1, 10'h010, 1'b0, 1'b1, 10'h000);
    @(negedge clk);
    #1;
    check(pred_taken == 1'b0, "R5 counter lowered below threshold", 32'(pred_taken), 0);

    // R1: reset mid-run clears table and history
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ref_reset();
    pred_pc = 32'h0000_0010;
    #1;
    check(ghist == 10'h0, "R1 history after second reset", 32'(ghist), 0);
    check(pred_taken == 1'b0, "R1 counter after second reset", 32'(pred_taken), 0);
    step(32'h0000_0010, 1'b1, 10'h004, 1'b1, 1'b1, 10'h000);
    step(32'h0000_0010, 1'b0, 10'h004, 1'b0, 1'b0, 10'h000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule